// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit load-store processor and works out, in the same cycle, the address of the next instruction. The decoder gives it a control class: plain sequential flow, branch if equal, branch if not equal, absolute jump, jump that saves a return address, or jump through a register. Alongside the class come the two register values to compare, the 16-bit branch displacement, the 26-bit jump field and a register-held target. From the current PC and these inputs the unit selects the next PC. On a cycle with its step enable high, it loads that value into the PC register.

For the call class, the unit also provides the return address, which is the current PC plus 4, together with a write enable. The register file uses these to update register 31. Fetch, decode and delay slots sit outside the block.

Top module: `npc_unit`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, the PC output reads 32'h0000_0000 until the first enabled clock edge.
- R2: On each clock edge with step_en high, the PC takes the value that next_pc showed before that edge. Class code 0 (sequential) gives next_pc = PC + 4, wrapping modulo 2^32.
- R3: On a clock edge with step_en low, the PC keeps its value.
- R4: A taken branch gives next_pc = PC + 4 + (sign-extended 16-bit displacement shifted left by 2). Negative displacements move the PC backwards.
- R5: Class code 1 (branch if equal) is taken when the two compared values are equal. Otherwise next_pc = PC + 4.
- R6: Class code 2 (branch if not equal) is taken when the two compared values differ. Otherwise next_pc = PC + 4.
- R7: Class code 3 (jump) gives next_pc = {bits [31:28] of PC + 4, 26-bit jump field, 2'b00}.
- R8: Class code 4 (jump and link) gives the same next_pc as R7. It also raises link_we and drives link_addr = PC + 4.
- R9: link_we is low for every class code other than 4.
- R10: Class code 5 (jump via register) gives next_pc = the register target with bits [1:0] cleared.
- R11: The unused class codes 6 and 7 act as sequential: next_pc = PC + 4 and link_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Clock enable for the PC register |
| flow_class | input | 3 | Control class code (0 to 5 used) |
| cmp_a | input | 32 | First compared register value |
| cmp_b | input | 32 | Second compared register value |
| br_disp | input | 16 | Branch displacement in words |
| jmp_field | input | 26 | Jump target field in words |
| reg_target | input | 32 | Register-held jump address |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Selected next program counter |
| link_addr | output | 32 | Return address (PC + 4) |
| link_we | output | 1 | Write enable for register 31 |

## Verification
The assertions check several rules on every cycle. The PC loads the previous next_pc when enabled and holds when disabled. link_we appears only for the call class and always carries PC + 4. next_pc stays word-aligned, and an untaken equality branch falls through to PC + 4. Other behaviours can only be shown by the bench's scenarios, which compare against a bench model: the exact branch and jump target arithmetic, sign extension of backward displacements, wraparound at the top of the address space, clearing of the low register-target bits, and the treatment of unused class codes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned DISP_W    = 16;
  localparam int unsigned JFIELD_W  = 26;
  localparam int unsigned WORD_SH   = 2;
  localparam int unsigned CLASS_W   = 3;
  localparam int unsigned LINK_REG  = 31;

  typedef enum logic [CLASS_W-1:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_JMP  = 3'd3,
    FLOW_CALL = 3'd4,
    FLOW_JREG = 3'd5
  } flow_class_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned WORD_SH = 2
) (
  input  logic [XLEN-1:0] pc_cur,
  output logic [XLEN-1:0] pc_plus
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << WORD_SH;

  always_comb begin
    pc_plus = pc_cur + STEP;
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned DISP_W   = 16,
  parameter int unsigned JFIELD_W = 26,
  parameter int unsigned WORD_SH  = 2
) (
  input  logic [XLEN-1:0]     pc_plus,
  input  logic [DISP_W-1:0]   br_disp,
  input  logic [JFIELD_W-1:0] jmp_field,
  input  logic [XLEN-1:0]     reg_target,
  output logic [XLEN-1:0]     br_addr,
  output logic [XLEN-1:0]     jmp_addr,
  output logic [XLEN-1:0]     jreg_addr
);
  localparam int unsigned EXT_W = XLEN - DISP_W - WORD_SH;
  localparam int unsigned HI_W  = XLEN - JFIELD_W - WORD_SH;

  logic [XLEN-1:0] disp_bytes;

  always_comb begin
    disp_bytes = {{EXT_W{br_disp[DISP_W-1]}}, br_disp, {WORD_SH{1'b0}}};
    br_addr    = pc_plus + disp_bytes;
  end

  generate
    if (HI_W > 0) begin : g_region
      always_comb jmp_addr = {pc_plus[XLEN-1 -: HI_W], jmp_field, {WORD_SH{1'b0}}};
    end else begin : g_flat
      always_comb jmp_addr = {jmp_field, {WORD_SH{1'b0}}};
    end
  endgenerate

  always_comb begin
    jreg_addr = {reg_target[XLEN-1:WORD_SH], {WORD_SH{1'b0}}};
  end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  output logic            same
);
  always_comb begin
    same = (cmp_a == cmp_b);
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [CLASS_W-1:0] flow_class,
  input  logic               same,
  input  logic [XLEN-1:0]    pc_plus,
  input  logic [XLEN-1:0]    br_addr,
  input  logic [XLEN-1:0]    jmp_addr,
  input  logic [XLEN-1:0]    jreg_addr,
  output logic [XLEN-1:0]    next_pc,
  output logic               link_we
);
  always_comb begin
    next_pc = pc_plus;
    link_we = 1'b0;
    case (flow_class)
      FLOW_BEQ:  if (same)  next_pc = br_addr;
      FLOW_BNE:  if (!same) next_pc = br_addr;
      FLOW_JMP:  next_pc = jmp_addr;
      FLOW_CALL: begin
        next_pc = jmp_addr;
        link_we = 1'b1;
      end
      FLOW_JREG: next_pc = jreg_addr;
      default:   next_pc = pc_plus;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic [CLASS_W-1:0]  flow_class,
  input  logic [XLEN-1:0]     cmp_a,
  input  logic [XLEN-1:0]     cmp_b,
  input  logic [DISP_W-1:0]   br_disp,
  input  logic [JFIELD_W-1:0] jmp_field,
  input  logic [XLEN-1:0]     reg_target,
  output logic [XLEN-1:0]     pc,
  output logic [XLEN-1:0]     next_pc,
  output logic [XLEN-1:0]     link_addr,
  output logic                link_we
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_plus;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] jmp_addr;
  logic [XLEN-1:0] jreg_addr;
  logic            same;

  npc_incr #(.XLEN(XLEN), .WORD_SH(WORD_SH)) u_incr (
    .pc_cur  (pc_q),
    .pc_plus (pc_plus)
  );

  npc_targets #(
    .XLEN(XLEN), .DISP_W(DISP_W), .JFIELD_W(JFIELD_W), .WORD_SH(WORD_SH)
  ) u_targets (
    .pc_plus    (pc_plus),
    .br_disp    (br_disp),
    .jmp_field  (jmp_field),
    .reg_target (reg_target),
    .br_addr    (br_addr),
    .jmp_addr   (jmp_addr),
    .jreg_addr  (jreg_addr)
  );

  npc_cmp #(.XLEN(XLEN)) u_cmp (
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .same  (same)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .flow_class (flow_class),
    .same       (same),
    .pc_plus    (pc_plus),
    .br_addr    (br_addr),
    .jmp_addr   (jmp_addr),
    .jreg_addr  (jreg_addr),
    .next_pc    (next_pc),
    .link_we    (link_we)
  );

  always_comb begin
    pc_d = pc_q;
    if (step_en) pc_d = next_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc        = pc_q;
  assign link_addr = pc_plus;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                step_en,
  input logic [CLASS_W-1:0]  flow_class,
  input logic [XLEN-1:0]     cmp_a,
  input logic [XLEN-1:0]     cmp_b,
  input logic [XLEN-1:0]     pc,
  input logic [XLEN-1:0]     next_pc,
  input logic [XLEN-1:0]     link_addr,
  input logic                link_we
);
  AST_STEP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc == $past(next_pc)); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc)); // R3
  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_class != FLOW_CALL) |-> !link_we); // R9
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_addr == pc + 32'd4); // R8
  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc[1:0] == 2'b00); // R10
  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_class == FLOW_BEQ && cmp_a != cmp_b) |-> next_pc == pc + 32'd4); // R5
endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .flow_class (flow_class),
  .cmp_a      (cmp_a),
  .cmp_b      (cmp_b),
  .pc         (pc),
  .next_pc    (next_pc),
  .link_addr  (link_addr),
  .link_we    (link_we)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [2:0]  flow_class;
  logic [31:0] cmp_a, cmp_b, reg_target;
  logic [15:0] br_disp;
  logic [25:0] jmp_field;
  logic [31:0] pc, next_pc, link_addr;
  logic        link_we;

  int tests = 0;
  int fails = 0;
  logic [31:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .flow_class(flow_class),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .br_disp(br_disp), .jmp_field(jmp_field),
    .reg_target(reg_target), .pc(pc), .next_pc(next_pc),
    .link_addr(link_addr), .link_we(link_we)
  );

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic [2:0] c,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] d,
      input logic [25:0] j, input logic [31:0] r);
    logic [31:0] seq;
    logic [31:0] br;
    seq = p + 32'd4;
    br  = seq + {{14{d[15]}}, d, 2'b00};
    case (c)
      3'd1: return (a == b) ? br : seq;
      3'd2: return (a != b) ? br : seq;
      3'd3, 3'd4: return {seq[31:28], j, 2'b00};
      3'd5: return {r[31:2], 2'b00};
      default: return seq;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, check combinational outputs, clock, check PC at next negedge.
  task automatic step(input string req, input logic en, input logic [2:0] c,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] d,
      input logic [25:0] j, input logic [31:0] r);
    logic [31:0] nx;
    step_en = en; flow_class = c; cmp_a = a; cmp_b = b;
    br_disp = d; jmp_field = j; reg_target = r;
    #1;
    nx = exp_next(model_pc, c, a, b, d, j, r);
    check({req, " next_pc"}, next_pc, nx);
    check({req, " link_we R9"}, {31'd0, link_we}, {31'd0, (c == 3'd4)});
    if (c == 3'd4) check({req, " link_addr R8"}, link_addr, model_pc + 32'd4);
    @(posedge clk);
    if (en) model_pc = nx;
    @(negedge clk);
    check({req, " pc"}, pc, model_pc);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst_n = 1'b0; step_en = 1'b0; flow_class = '0;
    cmp_a = '0; cmp_b = '0; br_disp = '0; jmp_field = '0; reg_target = '0;
    model_pc = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset", pc, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", pc, 32'h0);

    step("R2 seq", 1'b1, 3'd0, 0, 0, 0, 0, 0);
    step("R2 seq again", 1'b1, 3'd0, 0, 0, 0, 0, 0);
    step("R3 hold", 1'b0, 3'd3, 0, 0, 0, 26'h3FF_FFFF, 0);
    step("R10 jreg unaligned", 1'b1, 3'd5, 0, 0, 0, 0, 32'h1234_5677);
    step("R5 R4 beq taken fwd", 1'b1, 3'd1, 32'd7, 32'd7, 16'h0010, 0, 0);
    step("R5 beq not taken", 1'b1, 3'd1, 32'd7, 32'd8, 16'h0010, 0, 0);
    step("R6 R4 bne taken back", 1'b1, 3'd2, 32'd1, 32'd2, 16'hFFFF, 0, 0);
    step("R6 bne not taken", 1'b1, 3'd2, 32'd5, 32'd5, 16'h8000, 0, 0);
    step("R4 beq min disp", 1'b1, 3'd1, 0, 0, 16'h8000, 0, 0);
    step("R7 jump", 1'b1, 3'd3, 0, 0, 0, 26'h2AA_AAAB, 0);
    step("R8 call", 1'b1, 3'd4, 0, 0, 0, 26'h000_0100, 0);
    step("R11 code6", 1'b1, 3'd6, 32'd3, 32'd3, 16'h0004, 26'h1, 32'h40);
    step("R11 code7", 1'b1, 3'd7, 32'd3, 32'd3, 16'h0004, 26'h1, 32'h40);
    step("R10 jreg top", 1'b1, 3'd5, 0, 0, 0, 0, 32'hFFFF_FFFE);
    step("R2 wrap", 1'b1, 3'd0, 0, 0, 0, 0, 0);
    step("R10 jreg region", 1'b1, 3'd5, 0, 0, 0, 0, 32'hEFFF_FFFC);
    step("R7 region from PC+4", 1'b1, 3'd3, 0, 0, 0, 26'h000_0004, 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  c;
      c = 3'($urandom_range(0, 7));
      a = $urandom;
      b = ($urandom_range(0, 1) == 0) ? a : $urandom;
      step($sformatf("R2 R4 R5 R6 R7 R8 R9 R10 R11 random class %0d", c),
           ($urandom_range(0, 7) != 0), c, a, b, 16'($urandom),
           26'($urandom), $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule